// File: doc/BRIEF.md
# I2C Master Bus Timeout Timer

This block watches an I2C master for a stalled transfer. It counts whole I2C bit periods, using a one-cycle tick that the SCL generator emits once per bit period. If a programmed number of bit periods passes with no sign of bus progress, it sets a sticky timeout flag. Bus progress means any of four events: a write of the START control bit, a write of the STOP control bit, a falling edge on SCL, or a write of a new interval value. Each of these events restarts the count from zero.

The interval comes from an 8-bit value `to_val`. The timer expires on the (`to_val` + 1)-th bit tick after the most recent restart. A value of zero turns the timer off. Once the timer has expired, the counter stops and holds until the next restart event. The flag stays set until the controller clears it with `flag_clr` or until reset.

The SCL input is treated as asynchronous. It passes through a synchronizer of `SYNC_STAGES` flops, and a falling edge of the synchronized level becomes a one-cycle restart pulse. All interfaces are plain control and status pins, because no data stream passes through the block.

Top module: `i2c_bus_timeout`

## Requirements
- R1: With a nonzero `to_val` = N, `timeout_flag` goes to 1 on the clock edge of the (N+1)-th `bit_tick` after a restart. It stays 0 after only N ticks.
- R2: While `to_val` is 0, the timer is disabled, and no number of bit ticks sets `timeout_flag`.
- R3: A one-cycle `start_wr` pulse resets the count to zero, so N+1 further ticks are needed to expire.
- R4: A one-cycle `stop_wr` pulse resets the count to zero, in the same way as R3.
- R5: A falling edge of `scl_in`, after synchronization, resets the count to zero.
- R6: Once set, `timeout_flag` stays at 1 while `flag_clr` is low, regardless of further ticks.
- R7: A `flag_clr` pulse in a cycle without an expiry drives `timeout_flag` to 0 on the next edge.
- R8: After an expiry the counter holds. Further ticks without a restart event do not set the flag again, even after it has been cleared.
- R9: A `to_wr` pulse, which loads a new `to_val`, resets the count to zero.
- R10: When an expiry and `flag_clr` fall in the same cycle, the expiry wins and the flag stays at 1.
- R11: After reset, `timeout_flag` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| to_val | input | TO_W | Timeout interval in bit periods, minus one; 0 disables the timer |
| to_wr | input | 1 | One-cycle pulse when `to_val` is written |
| bit_tick | input | 1 | One-cycle pulse per I2C bit period |
| scl_in | input | 1 | Raw SCL line level |
| start_wr | input | 1 | One-cycle pulse when the START control bit is written |
| stop_wr | input | 1 | One-cycle pulse when the STOP control bit is written |
| flag_clr | input | 1 | One-cycle pulse that clears the timeout flag |
| timeout_flag | output | 1 | Sticky timeout interrupt flag |

## Verification
The assertions assume that `to_val` changes only in a cycle where `to_wr` is high. The internal count bound depends on this. They also assume that `bit_tick` is the only source of an expiry. The bench meets both assumptions: every change of `to_val` comes with a `to_wr` pulse, and each tick is a single-cycle pulse followed by an idle cycle. SCL is held high for several cycles around each falling edge, so the synchronizer always sees a clean level.

// File: rtl/i2c_to_pkg.sv
package i2c_to_pkg;
  typedef struct packed {
    logic start;
    logic stop;
    logic scl_fall;
    logic reload;
  } restart_src_t;
endpackage

// File: rtl/i2c_to_restart.sv
module i2c_to_restart
  import i2c_to_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         scl_in,
  input  logic         start_wr,
  input  logic         stop_wr,
  input  logic         to_wr,
  output restart_src_t src,
  output logic         restart
);
  localparam int ChainW = SYNC_STAGES + 1;

  logic [ChainW-1:0] chain;

  // Idle bus level is high, so the chain resets to ones to avoid a false edge.
  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[ChainW-2:0], scl_in};
  end

  always_comb begin
    src.start    = start_wr;
    src.stop     = stop_wr;
    src.reload   = to_wr;
    src.scl_fall = chain[ChainW-1] & ~chain[ChainW-2];
    restart      = |src;
  end
endmodule

// File: rtl/i2c_to_counter.sv
module i2c_to_counter #(
  parameter int TO_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TO_W-1:0] to_val,
  input  logic            bit_tick,
  input  logic            restart,
  output logic            expire
);
  logic [TO_W-1:0] cnt;
  logic            armed;
  logic            disabled;

  assign disabled = (to_val == '0);
  assign expire   = armed & bit_tick & ~restart & ~disabled & (cnt == to_val);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      armed <= 1'b1;
    end else if (restart) begin
      cnt   <= '0;
      armed <= 1'b1;
    end else if (disabled) begin
      cnt   <= '0;
    end else if (armed && bit_tick) begin
      if (cnt == to_val) armed <= 1'b0;
      else               cnt   <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/i2c_to_flag.sv
module i2c_to_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic flag_clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n)        flag <= 1'b0;
    else if (expire)   flag <= 1'b1;
    else if (flag_clr) flag <= 1'b0;
  end
endmodule

// File: rtl/i2c_bus_timeout.sv
module i2c_bus_timeout
  import i2c_to_pkg::*;
#(
  parameter int TO_W        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TO_W-1:0] to_val,
  input  logic            to_wr,
  input  logic            bit_tick,
  input  logic            scl_in,
  input  logic            start_wr,
  input  logic            stop_wr,
  input  logic            flag_clr,
  output logic            timeout_flag
);
  restart_src_t src;
  logic         restart;
  logic         expire;

  i2c_to_restart #(.SYNC_STAGES(SYNC_STAGES)) u_restart (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .start_wr(start_wr),
    .stop_wr(stop_wr), .to_wr(to_wr), .src(src), .restart(restart)
  );

  i2c_to_counter #(.TO_W(TO_W)) u_counter (
    .clk(clk), .rst_n(rst_n), .to_val(to_val), .bit_tick(bit_tick),
    .restart(restart), .expire(expire)
  );

  i2c_to_flag u_flag (
    .clk(clk), .rst_n(rst_n), .expire(expire), .flag_clr(flag_clr),
    .flag(timeout_flag)
  );
endmodule

// File: rtl/i2c_bus_timeout_chk.sv
module i2c_bus_timeout_chk #(
  parameter int TO_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [TO_W-1:0] to_val,
  input logic            to_wr,
  input logic            bit_tick,
  input logic            start_wr,
  input logic            stop_wr,
  input logic            flag_clr,
  input logic            timeout_flag,
  input logic [TO_W-1:0] cnt
);
  AST_RISE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_flag) |-> $past(bit_tick && to_val != '0)); // R2

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_flag && !flag_clr) |=> timeout_flag); // R6

  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !bit_tick) |=> !timeout_flag); // R7

  AST_START_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (start_wr && !timeout_flag) |=> !timeout_flag); // R3

  AST_STOP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_wr && !timeout_flag) |=> !timeout_flag); // R4

  AST_RELOAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    to_wr |=> (cnt == '0)); // R9

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (to_val != '0 && !to_wr) |-> (cnt <= to_val)); // R1
endmodule

bind i2c_bus_timeout i2c_bus_timeout_chk #(.TO_W(TO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .to_val(to_val), .to_wr(to_wr),
  .bit_tick(bit_tick), .start_wr(start_wr), .stop_wr(stop_wr),
  .flag_clr(flag_clr), .timeout_flag(timeout_flag), .cnt(u_counter.cnt)
);

// File: tb/sim_i2c_bus_timeout.sv
`timescale 1ns/1ps
module sim_i2c_bus_timeout;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] to_val = 8'd0;
  logic       to_wr = 1'b0, bit_tick = 1'b0, scl_in = 1'b1;
  logic       start_wr = 1'b0, stop_wr = 1'b0, flag_clr = 1'b0;
  logic       timeout_flag;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  i2c_bus_timeout u0 (
    .clk(clk), .rst_n(rst_n), .to_val(to_val), .to_wr(to_wr),
    .bit_tick(bit_tick), .scl_in(scl_in), .start_wr(start_wr),
    .stop_wr(stop_wr), .flag_clr(flag_clr), .timeout_flag(timeout_flag)
  );

  task automatic check(input string req, input logic exp);
    checks++;
    if (timeout_flag !== exp) begin
      errors++;
      $display("FAIL %s: timeout_flag=%0b expected=%0b", req, timeout_flag, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      bit_tick = 1'b1; @(negedge clk); bit_tick = 1'b0; @(negedge clk);
    end
  endtask

  task automatic load(input logic [7:0] v);
    to_val = v; to_wr = 1'b1; @(negedge clk); to_wr = 1'b0; @(negedge clk);
  endtask

  task automatic pulse_clr();
    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0; @(negedge clk);
  endtask

  task automatic pulse_start();
    start_wr = 1'b1; @(negedge clk); start_wr = 1'b0; @(negedge clk);
  endtask

  task automatic t_reset();
    check("R11 reset", 1'b0);
  endtask

  task automatic t_basic();
    load(8'd3);
    ticks(3); check("R1 before expiry", 1'b0);
    ticks(1); check("R1 at expiry", 1'b1);
  endtask

  task automatic t_sticky_halt();
    ticks(5); check("R6 sticky", 1'b1);
    pulse_clr(); check("R7 clear", 1'b0);
    ticks(10); check("R8 halted", 1'b0);
    pulse_start(); ticks(4); check("R8 rearmed by restart", 1'b1);
    pulse_clr();
  endtask

  task automatic t_disabled();
    load(8'd0);
    ticks(300); check("R2 disabled", 1'b0);
  endtask

  task automatic t_start();
    load(8'd3); ticks(2);
    pulse_start();
    ticks(3); check("R3 start restarts", 1'b0);
    ticks(1); check("R3 expiry after start", 1'b1);
    pulse_clr();
  endtask

  task automatic t_stop();
    load(8'd3); ticks(2);
    stop_wr = 1'b1; @(negedge clk); stop_wr = 1'b0; @(negedge clk);
    ticks(3); check("R4 stop restarts", 1'b0);
    ticks(1); check("R4 expiry after stop", 1'b1);
    pulse_clr();
  endtask

  task automatic t_scl();
    load(8'd3); ticks(2);
    scl_in = 1'b0; idle(5); scl_in = 1'b1; idle(5);
    ticks(3); check("R5 scl fall restarts", 1'b0);
    ticks(1); check("R5 expiry after scl fall", 1'b1);
    pulse_clr();
  endtask

  task automatic t_reload();
    load(8'd3); ticks(2);
    load(8'd3);
    ticks(3); check("R9 reload restarts", 1'b0);
    ticks(1); check("R9 expiry after reload", 1'b1);
    pulse_clr();
  endtask

  task automatic t_edges();
    load(8'd1);
    ticks(1); check("R1 TO=1 one tick", 1'b0);
    ticks(1); check("R1 TO=1 two ticks", 1'b1);
    pulse_clr();
    load(8'd255);
    ticks(255); check("R1 TO=255 before", 1'b0);
    ticks(1); check("R1 TO=255 at expiry", 1'b1);
    pulse_clr();
  endtask

  task automatic t_race();
    load(8'd1); ticks(2); check("R10 setup", 1'b1);
    pulse_start();
    ticks(1);
    bit_tick = 1'b1; flag_clr = 1'b1; @(negedge clk);
    bit_tick = 1'b0; flag_clr = 1'b0; @(negedge clk);
    check("R10 expiry beats clear", 1'b1);
    pulse_clr();
  endtask

  initial begin
    idle(3); rst_n = 1'b1; @(negedge clk);
    t_reset(); t_basic(); t_sticky_halt(); t_disabled(); t_start();
    t_stop(); t_scl(); t_reload(); t_edges(); t_race();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run ended=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule